// File: doc/BRIEF.md
# CRC-16 Frame Check Verifier

This block checks received frames that end in a two-byte CRC-16 frame check sequence using the polynomial x^16 + x^12 + x^5 + 1. Bytes arrive on a valid/start/end handshake. Each byte goes into a 16-bit shift-left CRC register, bit 0 first and bit 7 last. The check sequence bytes go through the same register as the payload. Every error-free frame then leaves one fixed remainder, so the verdict comes from comparing the register with that constant. The block never computes a separate CRC for comparison.

A build parameter picks one of two datapaths. One absorbs a whole byte per clock. The other absorbs one bit per clock and throttles the source with a ready signal. The running CRC is always visible in its transmitted form, which is the one's complement of the register, bit-reversed. Its low byte is the first check-sequence byte to send.

Top module: `crc16_chk`

## Requirements
- R1: After reset, `crc_out_o` is 16'h0000, `check_valid_o` is low and `in_ready_o` is high.
- R2: `crc_out_o` equals the bit-reversed one's complement of a register that starts at 16'hFFFF and is stepped with polynomial 16'h1021, bytes fed bit 0 first. For the ASCII bytes "123456789" it reads 16'h906E.
- R3: A byte with `in_sof_i` set presets the register in the same cycle it is absorbed, so frames may follow each other with no idle cycle.
- R4: A frame of at least 3 bytes whose last two bytes are `crc_out_o[7:0]` then `crc_out_o[15:8]`, as read after the payload, leaves residue 16'h1D0F and is reported with `check_ok_o` high.
- R5: A frame with any single flipped bit is reported with `check_ok_o` low.
- R6: `check_valid_o` is a one-cycle pulse. It rises in the cycle after the last bit of the `in_eof_i` byte is absorbed and at no other time.
- R7: While `in_ready_o` is high and `in_valid_i` is low, `crc_out_o` holds, whatever `in_sof_i`, `in_eof_i` and `in_data_i` carry.
- R8: A frame of fewer than 3 bytes gives `check_ok_o` low, even when its register matches the residue.
- R9: In the one-bit-per-clock variant, `in_ready_o` is low for the 7 cycles after a byte is accepted. A byte then costs 8 cycles, and `check_valid_o` rises 8 cycles after the `in_eof_i` byte is accepted.
- R10: In the one-bit-per-clock variant, bytes offered while `in_ready_o` is low are ignored, including their `in_sof_i` and `in_eof_i` flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Byte strobe |
| in_sof_i | input | 1 | First byte of a frame |
| in_eof_i | input | 1 | Last byte of a frame |
| in_data_i | input | 8 | Received byte |
| in_ready_o | output | 1 | Block can take a byte this cycle |
| check_valid_o | output | 1 | Verdict strobe |
| check_ok_o | output | 1 | Frame passed, valid with the strobe |
| crc_out_o | output | 16 | Complemented, bit-reversed running CRC |

## Verification
Every one-byte payload is sent as a correct three-byte frame. Each is followed at once by a copy with one bit flipped, and the flip position walks across all 24 bit positions. This separates a true residue match from a register that passes regardless, and it tests the preset at a back-to-back frame start.

The nine-byte ASCII string, with idle gaps that carry junk flags, anchors the bit order and the output reversal to a published value. Two-byte and one-byte frames probe the length floor; the all-zero two-byte frame does hit the residue. The bit-serial build sees the same patterns while junk bytes are offered during its busy cycles.

// File: rtl/crc16_chk_pkg.sv
package crc16_chk_pkg;
  localparam int unsigned CRC_W  = 16;
  localparam int unsigned BYTE_W = 8;

  typedef logic [CRC_W-1:0] crc_t;

  // one shift-left step, feedback into taps selected by poly
  function automatic crc_t crc_bit(crc_t r, logic d, crc_t poly);
    logic fb;
    fb = d ^ r[CRC_W-1];
    return {r[CRC_W-2:0], 1'b0} ^ (fb ? poly : '0);
  endfunction

  // complement and mirror, giving the transmitted byte order
  function automatic crc_t rev_inv(crc_t r);
    crc_t o;
    for (int i = 0; i < CRC_W; i++) o[i] = ~r[CRC_W-1-i];
    return o;
  endfunction
endpackage

// File: rtl/crc16_chk_step.sv
module crc16_chk_step
  import crc16_chk_pkg::*;
#(
  parameter int unsigned STEP_W = 8,
  parameter crc_t        POLY   = 16'h1021
) (
  input  crc_t              crc_i,
  input  logic [STEP_W-1:0] bits_i,
  output crc_t              crc_o
);
  crc_t chain [STEP_W+1];

  assign chain[0] = crc_i;
  for (genvar g = 0; g < STEP_W; g++) begin : g_bit
    assign chain[g+1] = crc_bit(chain[g], bits_i[g], POLY);
  end
  assign crc_o = chain[STEP_W];
endmodule

// File: rtl/crc16_chk_ser.sv
module crc16_chk_ser
  import crc16_chk_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              eof_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic              ready_o,
  output logic              acc_o,
  output logic              step_en_o,
  output logic              bit_o,
  output logic              done_o,
  output logic              last_o
);
  localparam int unsigned CNT_W = $clog2(BYTE_W + 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] sh_q;
  logic              last_q;

  assign ready_o   = (cnt_q == '0);
  assign acc_o     = valid_i && ready_o;
  assign step_en_o = acc_o || (cnt_q != '0);
  assign bit_o     = acc_o ? data_i[0] : sh_q[0];
  assign done_o    = (cnt_q == CNT_W'(1));
  assign last_o    = last_q;

  // bit 0 is absorbed on the accept edge, the rest over the next 7 cycles
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sh_q   <= '0;
      last_q <= 1'b0;
    end else if (acc_o) begin
      cnt_q  <= CNT_W'(BYTE_W - 1);
      sh_q   <= data_i >> 1;
      last_q <= eof_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
      sh_q  <= sh_q >> 1;
    end
  end

  // R9
  busy_after_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_o |=> !ready_o);
endmodule

// File: rtl/crc16_chk_judge.sv
module crc16_chk_judge
  import crc16_chk_pkg::*;
#(
  parameter int unsigned MIN_LEN = 3,
  parameter crc_t        RESIDUE = 16'h1D0F
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic byte_acc_i,
  input  logic sof_i,
  input  logic done_i,
  input  logic last_i,
  input  crc_t crc_next_i,
  output logic check_valid_o,
  output logic check_ok_o
);
  localparam int unsigned LEN_W = $clog2(MIN_LEN + 1);
  localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(MIN_LEN);

  logic [LEN_W-1:0] len_q, len_d;
  logic             fin;

  always_comb begin
    len_d = len_q;
    if (byte_acc_i) begin
      if (sof_i)                len_d = LEN_W'(1);
      else if (len_q != LEN_MAX) len_d = len_q + 1'b1;
    end
  end

  assign fin = done_i && last_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q         <= '0;
      check_valid_o <= 1'b0;
      check_ok_o    <= 1'b0;
    end else begin
      len_q         <= len_d;
      check_valid_o <= fin;
      check_ok_o    <= fin && (crc_next_i == RESIDUE) && (len_d == LEN_MAX);
    end
  end

  // R8
  short_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    check_ok_o |-> (check_valid_o && len_q == LEN_MAX));
endmodule

// File: rtl/crc16_chk.sv
module crc16_chk
  import crc16_chk_pkg::*;
#(
  parameter bit          SERIAL  = 1'b0,
  parameter crc_t        POLY    = 16'h1021,
  parameter crc_t        INIT    = 16'hFFFF,
  parameter crc_t        RESIDUE = 16'h1D0F,
  parameter int unsigned MIN_LEN = 3
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        in_valid_i,
  input  logic        in_sof_i,
  input  logic        in_eof_i,
  input  logic [7:0]  in_data_i,
  output logic        in_ready_o,
  output logic        check_valid_o,
  output logic        check_ok_o,
  output logic [15:0] crc_out_o
);
  localparam int unsigned STEP_W = SERIAL ? 1 : BYTE_W;

  logic              acc, step_en, done, last, preset;
  logic [STEP_W-1:0] step_bits;
  crc_t              crc_q, crc_base, crc_nx;

  if (SERIAL) begin : g_ser
    logic ser_bit;
    crc16_chk_ser u_ser (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .valid_i   (in_valid_i),
      .eof_i     (in_eof_i),
      .data_i    (in_data_i),
      .ready_o   (in_ready_o),
      .acc_o     (acc),
      .step_en_o (step_en),
      .bit_o     (ser_bit),
      .done_o    (done),
      .last_o    (last)
    );
    assign step_bits = ser_bit;

    // R6
    pulse_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      check_valid_o |-> in_ready_o);
  end else begin : g_par
    assign in_ready_o = 1'b1;
    assign acc        = in_valid_i;
    assign step_en    = acc;
    assign step_bits  = in_data_i;
    assign done       = acc;
    assign last       = in_eof_i;

    // R6
    pulse_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      check_valid_o |-> $past(in_valid_i && in_eof_i));
  end

  assign preset   = acc && in_sof_i;
  assign crc_base = preset ? INIT : crc_q;

  crc16_chk_step #(.STEP_W(STEP_W), .POLY(POLY)) u_step (
    .crc_i  (crc_base),
    .bits_i (step_bits),
    .crc_o  (crc_nx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      crc_q <= INIT;
    else if (step_en) crc_q <= crc_nx;
  end

  crc16_chk_judge #(.MIN_LEN(MIN_LEN), .RESIDUE(RESIDUE)) u_judge (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .byte_acc_i    (acc),
    .sof_i         (in_sof_i),
    .done_i        (done),
    .last_i        (last),
    .crc_next_i    (crc_nx),
    .check_valid_o (check_valid_o),
    .check_ok_o    (check_ok_o)
  );

  assign crc_out_o = rev_inv(crc_q);

  // R7
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_ready_o && !in_valid_i) |=> $stable(crc_out_o));

  // R4
  result_residue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    check_ok_o |-> (crc_q == RESIDUE));
endmodule

// File: tb/crc16_chk_tb_top.sv
module crc16_chk_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic p_valid = 0, p_sof = 0, p_eof = 0, p_cv, p_ok, p_rdy;
  logic [7:0] p_data = 0;
  logic [15:0] p_crc;
  logic s_valid = 0, s_sof = 0, s_eof = 0, s_cv, s_ok, s_rdy;
  logic [7:0] s_data = 0;
  logic [15:0] s_crc;

  int n_chk = 0, n_err = 0;
  logic [7:0] fr [16];
  logic [15:0] fcs;
  bit finished = 0;

  crc16_chk #(.SERIAL(1'b0)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(p_valid), .in_sof_i(p_sof),
    .in_eof_i(p_eof), .in_data_i(p_data), .in_ready_o(p_rdy),
    .check_valid_o(p_cv), .check_ok_o(p_ok), .crc_out_o(p_crc));

  crc16_chk #(.SERIAL(1'b1)) dut_s_i (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(s_valid), .in_sof_i(s_sof),
    .in_eof_i(s_eof), .in_data_i(s_data), .in_ready_o(s_rdy),
    .check_valid_o(s_cv), .check_ok_o(s_ok), .crc_out_o(s_crc));

  function automatic logic [15:0] upd(logic [15:0] r, logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      if (b[i] ^ r[15]) r = (r << 1) ^ 16'h1021;
      else              r = r << 1;
    end
    return r;
  endfunction

  function automatic logic [15:0] mirror_inv(logic [15:0] r);
    logic [15:0] o;
    for (int i = 0; i < 16; i++) o[i] = ~r[15-i];
    return o;
  endfunction

  task automatic chk(input bit good, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!good) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // append the FCS for an n-byte payload in fr
  task automatic build_good(input int n);
    logic [15:0] r = 16'hFFFF;
    for (int i = 0; i < n; i++) r = upd(r, fr[i]);
    fcs = mirror_inv(r);
    fr[n]   = fcs[7:0];
    fr[n+1] = fcs[15:8];
  endtask

  task automatic p_frame(input int len, input bit exp_ok, input string tag,
                         input int crc_at, input logic [15:0] crc_exp, input bit gaps);
    logic [15:0] held;
    for (int i = 0; i < len; i++) begin
      p_valid = 1; p_sof = (i == 0); p_eof = (i == len - 1); p_data = fr[i];
      @(negedge clk);
      if (i == crc_at) chk(p_crc == crc_exp, "R2 crc_out", p_crc, crc_exp);
      if (i < len - 1) begin
        chk(!p_cv, "R6 early pulse", 16'(p_cv), 16'h0);
        if (gaps) begin
          held = p_crc;
          p_valid = 0; p_sof = 1; p_eof = 1; p_data = ~fr[i];
          repeat (2) @(negedge clk);
          chk(p_crc == held && !p_cv, "R7 idle hold", p_crc, held);
        end
      end
    end
    chk(p_cv, "R6 pulse", 16'(p_cv), 16'h1);
    chk(p_ok == exp_ok, tag, 16'(p_ok), 16'(exp_ok));
  endtask

  task automatic p_idle();
    p_valid = 0; p_sof = 0; p_eof = 0;
    @(negedge clk);
    chk(!p_cv, "R6 single cycle", 16'(p_cv), 16'h0);
  endtask

  task automatic s_frame(input int len, input bit exp_ok, input string tag,
                         input int crc_at, input logic [15:0] crc_exp);
    for (int i = 0; i < len; i++) begin
      s_valid = 1; s_sof = (i == 0); s_eof = (i == len - 1); s_data = fr[i];
      @(negedge clk);
      for (int j = 0; j < 7; j++) begin
        chk(!s_rdy, "R9 busy", 16'(s_rdy), 16'h0);
        chk(!s_cv, "R6 early pulse", 16'(s_cv), 16'h0);
        // R10: junk with both flags while busy
        s_valid = 1; s_sof = 1; s_eof = 1; s_data = 8'hA5 ^ 8'(j);
        @(negedge clk);
      end
      chk(s_rdy, "R9 ready again", 16'(s_rdy), 16'h1);
      if (i == crc_at) chk(s_crc == crc_exp, "R2 serial crc_out", s_crc, crc_exp);
      if (i < len - 1) chk(!s_cv, "R6 early pulse", 16'(s_cv), 16'h0);
    end
    chk(s_cv, "R9 pulse timing", 16'(s_cv), 16'h1);
    chk(s_ok == exp_ok, tag, 16'(s_ok), 16'(exp_ok));
  endtask

  task automatic s_idle();
    s_valid = 0; s_sof = 0; s_eof = 0;
    @(negedge clk);
    chk(!s_cv, "R6 single cycle", 16'(s_cv), 16'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=%h expected=%h", 16'h0, 16'h1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk(p_crc == 16'h0000, "R1 crc reset", p_crc, 16'h0000);
    chk(!p_cv, "R1 valid reset", 16'(p_cv), 16'h0);
    chk(s_crc == 16'h0000, "R1 serial crc reset", s_crc, 16'h0000);
    chk(s_rdy && p_rdy, "R1 ready reset", 16'(s_rdy), 16'h1);

    // R2 anchor value, with idle gaps (R7)
    for (int i = 0; i < 9; i++) fr[i] = 8'h31 + 8'(i);
    build_good(9);
    chk(fcs == 16'h906E, "R2 model", fcs, 16'h906E);
    p_frame(11, 1'b1, "R4 ascii frame", 8, 16'h906E, 1'b1);
    p_idle();

    // R4/R5 exhaustive single-byte payloads, good then flipped, back to back
    for (int p = 0; p < 256; p++) begin
      int fb;
      fr[0] = 8'(p);
      build_good(1);
      p_frame(3, 1'b1, "R4 good frame", 0, fcs, 1'b0);
      fb = p % 24;
      fr[fb / 8] = fr[fb / 8] ^ (8'h1 << (fb % 8));
      p_frame(3, 1'b0, "R5 flipped frame", -1, 16'h0, 1'b0);
    end
    // R3: good frame straight after a failing one needs the preset
    fr[0] = 8'h5C; build_good(1);
    p_frame(3, 1'b1, "R3 back-to-back good", 0, fcs, 1'b0);
    p_idle();

    // R8 short frames; 00 00 does leave the residue
    fr[0] = 8'h00; fr[1] = 8'h00;
    p_frame(2, 1'b0, "R8 two-byte frame", -1, 16'h0, 1'b0);
    p_frame(1, 1'b0, "R8 one-byte frame", -1, 16'h0, 1'b0);
    p_idle();

    // serial variant
    for (int i = 0; i < 9; i++) fr[i] = 8'h31 + 8'(i);
    build_good(9);
    s_frame(11, 1'b1, "R4 serial ascii", 8, 16'h906E);
    s_idle();
    for (int p = 0; p < 32; p++) begin
      int fb;
      fr[0] = 8'(p * 7 + 3);
      build_good(1);
      s_frame(3, 1'b1, "R10 serial good with junk", 0, fcs);
      fb = (p * 5) % 24;
      fr[fb / 8] = fr[fb / 8] ^ (8'h1 << (fb % 8));
      s_frame(3, 1'b0, "R5 serial flipped", -1, 16'h0);
    end
    s_idle();
    fr[0] = 8'h00; fr[1] = 8'h00;
    s_frame(2, 1'b0, "R8 serial two-byte", -1, 16'h0);
    s_idle();

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule